// File: doc/BRIEF.md
# Burst Word Address Sequencer

This block produces the word address for a four-beat burst on a synchronous memory bus. A load cycle captures a full start address from outside the block. Each advance cycle after that moves the two lowest address bits to the next beat of the burst, while the upper bits stay fixed at the captured block. One input chooses the beat order for each advance. In linear order the low bits count up and wrap within the block. In interleaved order the low bits are the start bits XORed with the beat count.

The address leaves the block through a register. Whatever a clock edge does is visible on the output just after that edge. While the suspend input is high, every clock edge is ignored and all state, including the output, holds. A synchronous active-high reset clears the state to zero. The memory array, chip-select decoding and data paths are handled by other blocks.

Top module: `burst_addr_gen`

## Requirements
- R1: Each burst has four beats: the two lowest address bits (BW = 2) take four distinct values before they repeat.
- R2: On a rising edge with `stall` low and `adv` high, the burst moves forward one beat, and the new address appears on `burst_addr` after that edge.
- R3: On a rising edge with `stall` low and `adv` low, `burst_addr` becomes `ld_addr` as sampled at that edge. That address is beat 0 of a new burst.
- R4: With `ilv_mode` = 0 (linear), an advance sets the low two bits to the previous low bits plus 1, modulo 4. Starting from start bits s, the beats are s, s+1, s+2, s+3 (mod 4).
- R5: With `ilv_mode` = 1 (interleaved), the low two bits on beat k are s XOR k, where s is the start bits and k is the beat count mod 4. For s = 1 the order is 1, 0, 3, 2.
- R6: On a rising edge with `stall` high, `adv`, `ilv_mode` and `ld_addr` are ignored. `burst_addr` and the beat position both hold, so the burst resumes where it stopped.
- R7: An advance never changes `burst_addr[AW-1:2]`. A linear wrap from 3 to 0 does not carry into the upper bits.
- R8: On a rising edge with `rst` high, `burst_addr`, the captured block and the beat count all clear to zero. If advances follow with no load, the sequence runs from address 0.
- R9: After the fourth beat, further advances keep wrapping within the same four-word block until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | High: ignore this edge and hold all state |
| adv | input | 1 | High: advance one beat; low: load `ld_addr` |
| ilv_mode | input | 1 | 0 = linear order, 1 = interleaved order |
| ld_addr | input | AW | Start address captured on a load |
| burst_addr | output | AW | Current burst word address (registered) |

## Verification
Every result is due exactly one rising edge after the cycle that causes it: a load, an advance, a stall hold and a reset each show on `burst_addr` just after the edge that samples them. The driver sets the inputs on the falling edge and queues the value that the next rising edge must produce. The monitor waits for that rising edge and compares 2 ns later, so each queued item meets the output in the cycle it is due. Stalls are checked one cycle at a time, and the advance that follows a stall shows that the beat position was kept.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/bag_counter.sv
// Beat counter: cleared on load, stepped on advance, frozen when disabled.
module bag_counter #(
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          load,
  output logic [BW-1:0] cnt_q,
  output logic [BW-1:0] cnt_inc
);
  localparam logic [BW-1:0] STEP = 1;

  assign cnt_inc = cnt_q + STEP;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (en) begin
      if (load) cnt_q <= '0;
      else      cnt_q <= cnt_inc;
    end
  end
endmodule

// File: rtl/bag_order.sv
// Maps (start bits, beat offset) to the low address bits of a beat.
module bag_order
  import bag_pkg::*;
#(
  parameter int BW = 2
) (
  input  burst_order_e  order,
  input  logic [BW-1:0] start,
  input  logic [BW-1:0] offset,
  output logic [BW-1:0] beat_low
);
  always_comb begin
    case (order)
      ORD_INTERLEAVE: beat_low = start ^ offset;
      default:        beat_low = start + offset;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int AW = 18,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall,
  input  logic          adv,
  input  logic          ilv_mode,
  input  logic [AW-1:0] ld_addr,
  output logic [AW-1:0] burst_addr
);
  localparam int UW = AW - BW;

  logic          step_en;
  logic          do_load;
  logic [UW-1:0] base_q;
  logic [BW-1:0] start_q;
  logic [BW-1:0] cnt_q;
  logic [BW-1:0] cnt_inc;
  logic [BW-1:0] nxt_low;
  logic [AW-1:0] addr_q;

  assign step_en = ~stall;
  assign do_load = ~adv;

  bag_counter #(.BW(BW)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .en     (step_en),
    .load   (do_load),
    .cnt_q  (cnt_q),
    .cnt_inc(cnt_inc)
  );

  bag_order #(.BW(BW)) u_ord (
    .order   (burst_order_e'(ilv_mode)),
    .start   (start_q),
    .offset  (cnt_inc),
    .beat_low(nxt_low)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      start_q <= '0;
      addr_q  <= '0;
    end else if (step_en) begin
      if (do_load) begin
        base_q  <= ld_addr[AW-1:BW];
        start_q <= ld_addr[BW-1:0];
        addr_q  <= ld_addr;
      end else begin
        addr_q  <= {base_q, nxt_low};
      end
    end
  end

  assign burst_addr = addr_q;
endmodule

// File: rtl/bag_check.sv
module bag_check #(
  parameter int AW = 18,
  parameter int BW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          stall,
  input logic          adv,
  input logic          ilv_mode,
  input logic [AW-1:0] ld_addr,
  input logic [AW-1:0] burst_addr
);
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> burst_addr == '0);

  p_load_capture_r3: assert property (@(posedge clk) disable iff (rst)
    (!stall && !adv) |=> burst_addr == $past(ld_addr));

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(burst_addr));

  p_upper_fixed_r7: assert property (@(posedge clk) disable iff (rst)
    (!stall && adv) |=> burst_addr[AW-1:BW] == $past(burst_addr[AW-1:BW]));

  p_linear_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!stall && adv && !ilv_mode) |=>
      burst_addr[BW-1:0] == BW'($past(burst_addr[BW-1:0]) + 1'b1));

  p_ilv_moves_r5: assert property (@(posedge clk) disable iff (rst)
    (!stall && adv && ilv_mode) |=>
      burst_addr[BW-1:0] != $past(burst_addr[BW-1:0]));
endmodule

bind burst_addr_gen bag_check #(.AW(AW), .BW(BW)) u_bag_check (
  .clk       (clk),
  .rst       (rst),
  .stall     (stall),
  .adv       (adv),
  .ilv_mode  (ilv_mode),
  .ld_addr   (ld_addr),
  .burst_addr(burst_addr)
);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          stall = 1'b0;
  logic          adv = 1'b0;
  logic          ilv_mode = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [AW-1:0] burst_addr;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  logic [AW-1:0] exp_q[$];
  string         tag_q[$];

  // Reference model state
  logic [AW-1:0] m_out = '0;
  logic [AW-3:0] m_base = '0;
  int            m_start = 0;
  int            m_beat = 0;

  always #4 clk = ~clk;

  burst_addr_gen #(.AW(AW), .BW(2)) dut (
    .clk(clk), .rst(rst), .stall(stall), .adv(adv),
    .ilv_mode(ilv_mode), .ld_addr(ld_addr), .burst_addr(burst_addr)
  );

  // Driver: set inputs on the falling edge, queue the value due after the next rising edge
  task automatic cyc(input bit r, input bit s, input bit a, input bit m,
                     input logic [AW-1:0] addr, input string tag);
    int low;
    @(negedge clk);
    rst = r; stall = s; adv = a; ilv_mode = m; ld_addr = addr;
    if (r) begin
      m_base = '0; m_start = 0; m_beat = 0; m_out = '0;
    end else if (s) begin
      // hold everything
    end else if (!a) begin
      m_base = addr[AW-1:2]; m_start = int'(addr[1:0]); m_beat = 0; m_out = addr;
    end else begin
      m_beat = (m_beat + 1) % 4;
      low = m ? (m_start ^ m_beat) : ((m_start + m_beat) % 4);
      m_out = {m_base, 2'(low)};
    end
    exp_q.push_back(m_out);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [AW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_checks++;
        if (burst_addr !== e) begin
          n_errors++;
          $display("FAIL %s: burst_addr=%h expected %h", t, burst_addr, e);
        end
      end
    end
  end

  initial begin
    // R8: reset state
    cyc(1, 0, 0, 0, 18'h2ABCD, "R8");
    cyc(1, 0, 1, 0, 18'h1FFFF, "R8");
    // R8: advances straight after reset run from address 0
    cyc(0, 0, 1, 0, '0, "R8");
    cyc(0, 0, 1, 0, '0, "R8");

    // R3/R4/R7: linear burst with start bits 2 at the top of the space, no carry
    cyc(0, 0, 0, 0, 18'h3FFFE, "R3");
    cyc(0, 0, 1, 0, '0, "R4");
    cyc(0, 0, 1, 0, '0, "R7");
    cyc(0, 0, 1, 0, '0, "R1");
    // R9: keep wrapping within the block
    cyc(0, 0, 1, 0, '0, "R9");
    cyc(0, 0, 1, 0, '0, "R9");
    cyc(0, 0, 1, 0, '0, "R9");

    // R5: interleaved with start bits 1 -> 1,0,3,2,1,...
    cyc(0, 0, 0, 1, 18'h12345, "R3");
    cyc(0, 0, 1, 1, '0, "R5");
    cyc(0, 0, 1, 1, '0, "R5");
    // R6: stall with a load request and other inputs changing
    cyc(0, 1, 0, 0, 18'h00777, "R6");
    cyc(0, 1, 1, 0, 18'h3AAAA, "R6");
    cyc(0, 0, 1, 1, '0, "R6");
    cyc(0, 0, 1, 1, '0, "R9");
    cyc(0, 0, 1, 1, '0, "R9");

    // R5: interleaved with start bits 3 -> 3,2,1,0
    cyc(0, 0, 0, 1, 18'h0ABC7, "R3");
    cyc(0, 0, 1, 1, '0, "R5");
    cyc(0, 0, 1, 1, '0, "R2");
    cyc(0, 0, 1, 1, '0, "R1");

    // R3: back-to-back loads
    cyc(0, 0, 0, 0, 18'h00003, "R3");
    cyc(0, 0, 0, 1, 18'h2C0DE, "R3");
    // R4: linear from start bits 3 -> 3,0,1,2, with a stall in between
    cyc(0, 0, 0, 0, 18'h15553, "R3");
    cyc(0, 0, 1, 0, '0, "R4");
    cyc(0, 1, 1, 1, '0, "R6");
    cyc(0, 0, 1, 0, '0, "R4");
    cyc(0, 0, 1, 0, '0, "R7");

    // R8: reset in the middle of a burst, then advance
    cyc(1, 0, 1, 0, '0, "R8");
    cyc(0, 0, 1, 1, '0, "R8");
    cyc(0, 0, 1, 1, '0, "R8");

    cyc(0, 1, 1, 0, '0, "R6");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule